// File: doc/BRIEF.md
# Maskable Burst Address Counter

This block generates addresses for one port of a synchronous memory. A start address taken from the external address bus is loaded into a counter, and the counter then steps by one on each enabled clock edge to produce the addresses of a burst. A mask register selects a run of low-order bits that form the counting field. Increments and counter clears touch only that field. Bits above the field keep their loaded value, and a wrap of the field never carries into them.

All control inputs are active low and are sampled on the rising clock edge. When the mask-access select is high, the strobe, enable and clear inputs act on the counter. When it is low, they act on the mask register, and the address output shows the mask instead of the counter. A wrap flag output goes low when an increment brings the counting field to all ones. An asynchronous active-low master reset brings the block to a known state. The block has no streaming data path, so every pin is a plain level signal.

Top module: `burst_addr_gen`

## Requirements
- R1: While the master reset `rst_n` is low, the counter is zero, the mask is all ones and `cnt_int_n` is high. These values appear on the outputs without waiting for a clock edge.
- R2: With `msk_sel_n` high, `cntrst_n` high and `ads_n` low, the counter takes the value of `addr_in` on the clock edge.
- R3: With `msk_sel_n`, `ads_n` and `cntrst_n` high and `cnten_n` low, the bits of the counter under the mask increase by one on the clock edge. The bits outside the mask are unchanged, and a field at all ones wraps to zero without changing the upper bits.
- R4: With `msk_sel_n` high and `cntrst_n` low, the bits under the mask clear to zero and the bits outside it are kept. This happens whatever the levels of `ads_n` and `cnten_n`.
- R5: When `ads_n` and `cnten_n` are both low, with `cntrst_n` high and `msk_sel_n` high, the load wins and no increment takes place.
- R6: With `msk_sel_n` low and `ads_n` low, the mask is written from `addr_in` in contiguous form. Mask bit 0 is always 1, and mask bit i (i>0) is 1 only when `addr_in` bits 1 through i are all 1. With `msk_sel_n` low and `cntrst_n` low, the mask becomes all ones, and this takes priority over the write. No mask operation changes the counter.
- R7: `addr_out` shows the mask while `msk_sel_n` is low and the counter while it is high.
- R8: With `msk_sel_n` low, `cnten_n` has no effect on either the mask or the counter.
- R9: `cnt_int_n` goes low on the edge of an increment that leaves the masked field at all ones. It returns high on the edge of an increment, load or clear that leaves the field below all ones. A load that leaves the field at all ones keeps the flag at its previous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| ads_n | input | 1 | Active-low address strobe (load / mask write) |
| cnten_n | input | 1 | Active-low counter enable |
| cntrst_n | input | 1 | Active-low counter clear (mask set in mask mode) |
| msk_sel_n | input | 1 | Active-low mask register select |
| addr_in | input | ADDR_W | External address or mask value |
| addr_out | output | ADDR_W | Current counter, or mask while mask is selected |
| cnt_int_n | output | 1 | Active-low wrap flag of the masked field |

## Verification
Three counter functions can be requested in the same cycle: clear, load and increment. Two collisions matter most. A clear asserted together with the strobe and the enable must leave the upper bits intact and zero the field. A strobe asserted together with the enable must load exactly `addr_in` with no step. Both collisions are driven deliberately with a narrow mask and distinctive upper bits, so that a wrong winner or a carry shows in the address. The scoreboard judges each result against an independent model of the requirements, in the cycle after the edge.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_CNT_CLR = 3'd1,
    OP_CNT_LD  = 3'd2,
    OP_CNT_INC = 3'd3,
    OP_MSK_SET = 3'd4,
    OP_MSK_LD  = 3'd5
  } bac_op_e;
endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic    ads_n,
  input  logic    cnten_n,
  input  logic    cntrst_n,
  input  logic    msk_sel_n,
  output bac_op_e op
);
  // Fixed priority: clear over load over increment; mask mode has no step.
  always_comb begin
    op = OP_NONE;
    if (!msk_sel_n) begin
      if (!cntrst_n)   op = OP_MSK_SET;
      else if (!ads_n) op = OP_MSK_LD;
    end else begin
      if (!cntrst_n)     op = OP_CNT_CLR;
      else if (!ads_n)   op = OP_CNT_LD;
      else if (!cnten_n) op = OP_CNT_INC;
    end
  end
endmodule

// File: rtl/bac_mask_reg.sv
module bac_mask_reg
  import bac_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bac_op_e      op,
  input  logic [W-1:0] din,
  output logic [W-1:0] mask
);
  logic [W-1:0] fill;

  // Convert any input into a run of ones starting at bit 0.
  always_comb begin
    fill[0] = 1'b1;
    for (int i = 1; i < W; i++) fill[i] = fill[i-1] & din[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 mask <= '1;
    else if (op == OP_MSK_SET)  mask <= '1;
    else if (op == OP_MSK_LD)   mask <= fill;
  end

  // R6: mask is always a contiguous run from bit 0
  p_mask_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask[0] && ((mask & (mask + 1'b1)) == '0));

  // R8: mask changes only on a mask operation
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_MSK_SET && op != OP_MSK_LD) |=> $stable(mask));

  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MSK_SET) |=> (mask == '1));
endmodule

// File: rtl/bac_counter.sv
module bac_counter
  import bac_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bac_op_e      op,
  input  logic [W-1:0] din,
  input  logic [W-1:0] mask,
  output logic [W-1:0] cnt,
  output logic         wrap_n
);
  logic [W-1:0] stepped;
  logic [W-1:0] nxt_inc;

  assign stepped = cnt + 1'b1;
  assign nxt_inc = (cnt & ~mask) | (stepped & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      wrap_n <= 1'b1;
    end else begin
      unique case (op)
        OP_CNT_CLR: begin
          cnt    <= cnt & ~mask;
          wrap_n <= 1'b1;
        end
        OP_CNT_LD: begin
          cnt <= din;
          if ((din & mask) != mask) wrap_n <= 1'b1;
        end
        OP_CNT_INC: begin
          cnt    <= nxt_inc;
          wrap_n <= ((nxt_inc & mask) != mask);
        end
        default: ;
      endcase
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CNT_LD) |=> (cnt == $past(din)));

  p_clr_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CNT_CLR) |=> ((cnt & mask) == '0) && ((cnt & ~mask) == $past(cnt & ~mask)));

  p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CNT_INC) |=> ((cnt & ~mask) == $past(cnt & ~mask)));

  p_int_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CNT_INC && (((cnt + 1'b1) & mask) == mask)) |=> !wrap_n);

  p_int_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CNT_CLR) |=> wrap_n);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bac_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic              cnten_n,
  input  logic              cntrst_n,
  input  logic              msk_sel_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              cnt_int_n
);
  bac_op_e           op;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] cnt;

  bac_decode u_decode (
    .ads_n     (ads_n),
    .cnten_n   (cnten_n),
    .cntrst_n  (cntrst_n),
    .msk_sel_n (msk_sel_n),
    .op        (op)
  );

  bac_mask_reg #(.W(ADDR_W)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .din   (addr_in),
    .mask  (mask)
  );

  bac_counter #(.W(ADDR_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .din    (addr_in),
    .mask   (mask),
    .cnt    (cnt),
    .wrap_n (cnt_int_n)
  );

  assign addr_out = msk_sel_n ? cnt : mask;

  // R6 / R8: counter untouched while the mask is selected
  p_cnt_stable_msk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !msk_sel_n |=> $stable(cnt));

  // R5: strobe beats enable
  p_ld_over_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_sel_n && cntrst_n && !ads_n && !cnten_n) |=> (cnt == $past(addr_in)));
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ads_n = 1'b1, cnten_n = 1'b1, cntrst_n = 1'b1, msk_sel_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          cnt_int_n;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cnten_n(cnten_n),
    .cntrst_n(cntrst_n), .msk_sel_n(msk_sel_n), .addr_in(addr_in),
    .addr_out(addr_out), .cnt_int_n(cnt_int_n)
  );

  typedef struct { logic [AW-1:0] addr; logic irq_n; string tag; } exp_t;
  exp_t          sb[$];
  logic [AW-1:0] m_cnt, m_mask;
  logic          m_int_n;
  int            total = 0, bad = 0;
  bit            done = 1'b0;

  function automatic logic [AW-1:0] contig(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    r[0] = 1'b1;
    for (int i = 1; i < AW; i++) r[i] = r[i-1] & v[i];
    return r;
  endfunction

  // Driver: apply one cycle of control and push the expected result.
  task automatic step(input logic ads, input logic cen, input logic crst,
                      input logic msk, input logic [AW-1:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    ads_n = ads; cnten_n = cen; cntrst_n = crst; msk_sel_n = msk; addr_in = a;
    if (!msk) begin
      if (!crst)     m_mask = '1;
      else if (!ads) m_mask = contig(a);
    end else if (!crst) begin
      m_cnt = m_cnt & ~m_mask; m_int_n = 1'b1;
    end else if (!ads) begin
      m_cnt = a;
      if ((a & m_mask) != m_mask) m_int_n = 1'b1;
    end else if (!cen) begin
      m_cnt = (m_cnt & ~m_mask) | ((m_cnt + 1'b1) & m_mask);
      m_int_n = ((m_cnt & m_mask) != m_mask);
    end
    e.addr = msk ? m_cnt : m_mask; e.irq_n = m_int_n; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare after each edge.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (addr_out !== e.addr || cnt_int_n !== e.irq_n) begin
          bad++;
          $display("FAIL %s: addr=%h int_n=%b expected addr=%h int_n=%b",
                   e.tag, addr_out, cnt_int_n, e.addr, e.irq_n);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_cnt = '0; m_mask = '1; m_int_n = 1'b1;
    #25;
    total++;
    if (addr_out !== '0 || cnt_int_n !== 1'b1) begin
      bad++;
      $display("FAIL R1: addr=%h int_n=%b expected addr=0 int_n=1", addr_out, cnt_int_n);
    end
    @(negedge clk); rst_n = 1'b1;
    step(1,1,1,0,'0,        "R1 mask readback after reset");
    step(0,1,1,1,18'h000F0, "R2 load");
    step(1,0,1,1,'0,        "R3 increment");
    step(1,0,1,1,'0,        "R3 increment");
    step(1,1,1,1,'0,        "R3 idle hold");
    step(1,1,0,0,'0,        "R6 mask set all ones");
    step(0,1,1,0,18'h0000F, "R6 mask write 0xF");
    step(1,1,1,0,'0,        "R7 mask readback");
    step(0,1,1,1,18'h2300D, "R2 load upper bits");
    step(1,0,1,1,'0,        "R3 increment to E");
    step(1,0,1,1,'0,        "R9 field all ones flag low");
    step(1,1,1,1,'0,        "R9 flag held while idle");
    step(1,0,1,1,'0,        "R3 wrap without carry");
    step(0,1,1,1,18'h1555F, "R9 load all-ones field");
    step(1,0,1,1,'0,        "R3 wrap after load");
    step(0,1,1,1,18'h2A00E, "R2 load");
    step(1,0,1,1,'0,        "R9 flag low again");
    step(0,0,0,1,18'h3FFFF, "R4 clear beats load and enable");
    step(0,0,1,1,18'h1234A, "R5 load beats enable");
    step(1,0,1,1,'0,        "R3 increment after collision");
    step(1,0,1,0,'0,        "R8 enable in mask mode");
    step(1,0,1,1,'0,        "R8 counter unchanged then step");
    step(0,1,1,0,18'h0000B, "R6 noncontiguous mask write");
    step(1,1,1,0,'0,        "R7 readback contiguous mask");
    step(0,1,1,1,18'h30001, "R2 load with 2-bit field");
    step(1,0,1,1,'0,        "R3 step 2-bit field");
    step(1,0,1,1,'0,        "R9 2-bit field all ones");
    step(1,0,1,1,'0,        "R3 2-bit field wrap");
    step(0,0,0,0,18'h00000, "R6 mask set beats write");
    step(1,1,0,1,'0,        "R4 clear full field");
    step(1,1,1,1,'0,        "final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule